// File: doc/BRIEF.md
# Software Triggered Virtual Interrupt Generator

This block lets bus masters raise interrupts purely by software. A master writes an interrupt number, a type select and a valid flag into a generation register. The block then produces a one-clock pulse on the matching interrupt line. There are 20 request lines and 4 non-maskable lines. Request lines 0 to 15 feed the virtual interrupt inputs of the processing cores. Request 16 drives an external maskable interrupt output. Request 17 drives an external non-maskable output. Requests 18 and 19 feed the interrupt inputs of two communication engines. The 4 non-maskable lines feed the cores' virtual non-maskable inputs.

Two write ports are provided, one for the core side and one for an external host. Both ports can write in the same clock. Their generation requests are merged, and so are their clear requests, so no arbitration is needed.

For every line, a sticky status bit records that the line has fired at least once. Software clears a status bit by writing a one to its position. A set status bit never stops the same interrupt from being generated again. One read port returns the status registers through a registered read path.

Top module: `soft_irq_gen`

## Requirements
- R1: After reset, and while reset is held, every interrupt output is 0 and both status registers read 0.
- R2: A write to register address 0 with bit 8 = 1 (valid), bit 7 = 0 (request type) and bits 4:0 = N, with N in 0..15, drives `core_virq[N]` high for exactly one clock. That clock is the one that follows the accepting clock edge.
- R3: The same kind of write with N = 16 pulses `ext_int`, N = 17 pulses `ext_nmi`, N = 18 pulses `ceng_irq[0]` and N = 19 pulses `ceng_irq[1]`. The timing is the same as in R2.
- R4: A write to address 0 with bit 8 = 1, bit 7 = 1 (non-maskable type) and bits 4:0 = M, with M in 0..3, pulses `core_vnmi[M]` for one clock after the accepting edge.
- R5: A generation write with bit 8 = 0 is ignored. So is one whose index is above 19 (request type) or above 3 (non-maskable type). Neither produces a pulse or changes any status bit.
- R6: Request status is read at address 1, with bit N standing for request N. Non-maskable status is read at address 2, with bit M standing for line M. A status bit becomes 1 at the same edge that starts the interrupt's pulse. Addresses 0 and 3 read 0.
- R7: Generating an interrupt whose status bit is already set still produces its pulse. The bit stays set.
- R8: Writing to address 1 or 2 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R9: When a clear and a generation of the same status bit land at the same edge, from the two write ports, the generation wins and the bit stays 1.
- R10: Generation writes from both ports at the same edge, naming different interrupts, pulse both lines in the same clock.
- R11: `rd_data` is registered. It shows the addressed register in the clock after an edge where `rd_en` = 1, and it is 0 after an edge where `rd_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_PORTS | Write strobe per port (port 0 core side, port 1 host) |
| wr_addr | input | NUM_PORTS*2 | Register address per port, port p in bits [2p+1:2p] |
| wr_data | input | NUM_PORTS*DATA_W | Write data per port, port p in slice p |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read register address |
| rd_data | output | DATA_W | Registered read data |
| core_virq | output | NUM_CORE | Virtual interrupt pulses to the cores (requests 0..15) |
| ext_int | output | 1 | External maskable interrupt pulse (request 16) |
| ext_nmi | output | 1 | External non-maskable interrupt pulse (request 17) |
| ceng_irq | output | NUM_CE | Communication engine interrupt pulses (requests 18, 19) |
| core_vnmi | output | NUM_NMI | Virtual non-maskable interrupt pulses to the cores |

## Verification
An interrupt pulse and the setting of its status bit both come from the clock edge that accepts the write. The bench therefore drives each write before an edge and samples all outputs at the following falling edge. It then waits one more full clock and checks that the pulse has dropped to zero. Status is read through the registered read port, so a read issued in the clock after a write is sampled one falling edge after its own edge. That read reflects every write accepted before it. Clear-versus-generate and dual-port cases are driven in a single write cycle, and the status is then read back.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Register address width and generation-word field positions.
  localparam int REG_AW        = 2;
  localparam int GEN_VALID_BIT = 8;
  localparam int GEN_TYPE_BIT  = 7;
  localparam int IDX_FIELD_W   = 5;   // index field [4:0], up to 32 lines

  typedef enum logic [REG_AW-1:0] {
    REG_GEN      = 2'd0,
    REG_REQ_STAT = 2'd1,
    REG_NMI_STAT = 2'd2,
    REG_RSVD     = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/sirq_port_dec.sv
// Decodes one write port into one-hot generate and clear vectors.
module sirq_port_dec
  import sirq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_REQ = 20,
  parameter int NUM_NMI = 4
) (
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NUM_REQ-1:0]     gen_req,
  output logic [NUM_NMI-1:0]     gen_nmi,
  output logic [NUM_REQ-1:0]     clr_req,
  output logic [NUM_NMI-1:0]     clr_nmi
);

  logic                   gen_hit;
  logic                   is_nmi;
  logic [IDX_FIELD_W-1:0] idx;
  logic                   unused_wdata;

  assign gen_hit      = wr_en && (reg_sel_e'(addr) == REG_GEN) && wdata[GEN_VALID_BIT];
  assign is_nmi       = wdata[GEN_TYPE_BIT];
  assign idx          = wdata[IDX_FIELD_W-1:0];
  assign unused_wdata = ^wdata;

  // Out-of-range indices match no line and fall away.
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    assign gen_req[i] = gen_hit && !is_nmi && (idx == IDX_FIELD_W'(i));
  end

  for (genvar j = 0; j < NUM_NMI; j++) begin : g_nmi
    assign gen_nmi[j] = gen_hit && is_nmi && (idx == IDX_FIELD_W'(j));
  end

  assign clr_req = (wr_en && reg_sel_e'(addr) == REG_REQ_STAT) ? wdata[NUM_REQ-1:0] : '0;
  assign clr_nmi = (wr_en && reg_sel_e'(addr) == REG_NMI_STAT) ? wdata[NUM_NMI-1:0] : '0;

endmodule

// File: rtl/sirq_sticky.sv
// Sticky status bits: set wins over a same-edge write-one clear.
module sirq_sticky #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | set;
  end

endmodule

// File: rtl/sirq_pulse.sv
// Registers the one-cycle interrupt pulses.
module sirq_pulse #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fire,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= fire;
  end

endmodule

// File: rtl/sirq_rdmux.sv
// Registered read path for the status registers.
module sirq_rdmux
  import sirq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_REQ = 20,
  parameter int NUM_NMI = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   rd_addr,
  input  logic [NUM_REQ-1:0]  req_stat,
  input  logic [NUM_NMI-1:0]  nmi_stat,
  output logic [DATA_W-1:0]   rd_data
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    case (reg_sel_e'(rd_addr))
      REG_REQ_STAT: sel = DATA_W'(req_stat);
      REG_NMI_STAT: sel = DATA_W'(nmi_stat);
      default:      sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
    else            rd_data <= '0;
  end

endmodule

// File: rtl/soft_irq_gen.sv
// Software triggered virtual interrupt generator, top level.
module soft_irq_gen
  import sirq_pkg::*;
#(
  parameter  int NUM_PORTS = 2,
  parameter  int DATA_W    = 32,
  parameter  int NUM_CORE  = 16,
  parameter  int NUM_CE    = 2,
  parameter  int NUM_NMI   = 4,
  localparam int NUM_REQ   = NUM_CORE + 2 + NUM_CE
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          wr_en,
  input  logic [NUM_PORTS*REG_AW-1:0]   wr_addr,
  input  logic [NUM_PORTS*DATA_W-1:0]   wr_data,
  input  logic                          rd_en,
  input  logic [REG_AW-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic [NUM_CORE-1:0]           core_virq,
  output logic                          ext_int,
  output logic                          ext_nmi,
  output logic [NUM_CE-1:0]             ceng_irq,
  output logic [NUM_NMI-1:0]            core_vnmi
);

  localparam int EXT_INT_IDX = NUM_CORE;
  localparam int EXT_NMI_IDX = NUM_CORE + 1;
  localparam int CE_BASE     = NUM_CORE + 2;
  localparam int PULSE_W     = NUM_REQ + NUM_NMI;

  logic [NUM_REQ-1:0] p_gen_req [NUM_PORTS];
  logic [NUM_NMI-1:0] p_gen_nmi [NUM_PORTS];
  logic [NUM_REQ-1:0] p_clr_req [NUM_PORTS];
  logic [NUM_NMI-1:0] p_clr_nmi [NUM_PORTS];

  logic [NUM_REQ-1:0] gen_req;
  logic [NUM_NMI-1:0] gen_nmi;
  logic [NUM_REQ-1:0] clr_req;
  logic [NUM_NMI-1:0] clr_nmi;
  logic [NUM_REQ-1:0] req_stat;
  logic [NUM_NMI-1:0] nmi_stat;
  logic [PULSE_W-1:0] pulse_q;
  logic [NUM_REQ-1:0] req_pulse;
  logic [NUM_NMI-1:0] nmi_pulse;

  // One decoder per write port.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sirq_port_dec #(
      .DATA_W  (DATA_W),
      .NUM_REQ (NUM_REQ),
      .NUM_NMI (NUM_NMI)
    ) u_dec (
      .wr_en   (wr_en[p]),
      .addr    (wr_addr[p*REG_AW +: REG_AW]),
      .wdata   (wr_data[p*DATA_W +: DATA_W]),
      .gen_req (p_gen_req[p]),
      .gen_nmi (p_gen_nmi[p]),
      .clr_req (p_clr_req[p]),
      .clr_nmi (p_clr_nmi[p])
    );
  end

  // Merge the ports: generations and clears simply OR together.
  always_comb begin
    gen_req = '0;
    gen_nmi = '0;
    clr_req = '0;
    clr_nmi = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      gen_req |= p_gen_req[p];
      gen_nmi |= p_gen_nmi[p];
      clr_req |= p_clr_req[p];
      clr_nmi |= p_clr_nmi[p];
    end
  end

  sirq_sticky #(.W(NUM_REQ)) u_req_stat (
    .clk (clk), .rst (rst), .set (gen_req), .clr (clr_req), .q (req_stat)
  );

  sirq_sticky #(.W(NUM_NMI)) u_nmi_stat (
    .clk (clk), .rst (rst), .set (gen_nmi), .clr (clr_nmi), .q (nmi_stat)
  );

  sirq_pulse #(.W(PULSE_W)) u_pulse (
    .clk (clk), .rst (rst), .fire ({gen_nmi, gen_req}), .q (pulse_q)
  );

  sirq_rdmux #(
    .DATA_W  (DATA_W),
    .NUM_REQ (NUM_REQ),
    .NUM_NMI (NUM_NMI)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .req_stat (req_stat),
    .nmi_stat (nmi_stat),
    .rd_data  (rd_data)
  );

  // Fixed routing of request slots to their destinations.
  assign req_pulse = pulse_q[NUM_REQ-1:0];
  assign nmi_pulse = pulse_q[PULSE_W-1:NUM_REQ];
  assign core_virq = req_pulse[NUM_CORE-1:0];
  assign ext_int   = req_pulse[EXT_INT_IDX];
  assign ext_nmi   = req_pulse[EXT_NMI_IDX];
  assign ceng_irq  = req_pulse[CE_BASE +: NUM_CE];
  assign core_vnmi = nmi_pulse;

endmodule

// File: rtl/sirq_chk.sv
// Property checker, bound to soft_irq_gen.
module sirq_chk #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_REQ   = 20,
  parameter int NUM_NMI   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_PORTS-1:0] wr_en,
  input logic [NUM_REQ-1:0]   gen_req,
  input logic [NUM_NMI-1:0]   gen_nmi,
  input logic [NUM_REQ-1:0]   clr_req,
  input logic [NUM_NMI-1:0]   clr_nmi,
  input logic [NUM_REQ-1:0]   req_stat,
  input logic [NUM_NMI-1:0]   nmi_stat,
  input logic [NUM_REQ-1:0]   req_pulse,
  input logic [NUM_NMI-1:0]   nmi_pulse
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (req_stat == '0 && nmi_stat == '0 && req_pulse == '0 && nmi_pulse == '0));

  a_r5_idle_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> (req_pulse == '0 && nmi_pulse == '0));

  a_r6_pulse_has_status: assert property (@(posedge clk) disable iff (rst)
    ((req_pulse & ~req_stat) == '0) && ((nmi_pulse & ~nmi_stat) == '0));

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(req_stat) & ~$past(clr_req) & ~req_stat) == '0) &&
             (($past(nmi_stat) & ~$past(clr_nmi) & ~nmi_stat) == '0));

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_stat & $past(clr_req & ~gen_req)) == '0) &&
             ((nmi_stat & $past(clr_nmi & ~gen_nmi)) == '0));

  a_r9_generate_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_stat & $past(gen_req)) == $past(gen_req)) &&
             ((nmi_stat & $past(gen_nmi)) == $past(gen_nmi)));

endmodule

bind soft_irq_gen sirq_chk #(
  .NUM_PORTS (NUM_PORTS),
  .NUM_REQ   (NUM_REQ),
  .NUM_NMI   (NUM_NMI)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .gen_req   (gen_req),
  .gen_nmi   (gen_nmi),
  .clr_req   (clr_req),
  .clr_nmi   (clr_nmi),
  .req_stat  (req_stat),
  .nmi_stat  (nmi_stat),
  .req_pulse (req_pulse),
  .nmi_pulse (nmi_pulse)
);

// File: tb/sim_soft_irq_gen.sv
module sim_soft_irq_gen;

  localparam int CLK_P  = 10;
  localparam int DW     = 32;
  localparam int NVEC   = 14;
  localparam int WDOG   = 20000;

  // Each vector: {generation word [32:24], expected pulse image [23:0]}.
  // Pulse image: [15:0] core_virq, 16 ext_int, 17 ext_nmi, [19:18] ceng_irq, [23:20] core_vnmi.
  localparam logic [32:0] VEC [NVEC] = '{
    {9'h100, 24'h000001},  // R2 idx 0
    {9'h107, 24'h000080},  // R2 idx 7
    {9'h10F, 24'h008000},  // R2 idx 15
    {9'h110, 24'h010000},  // R3 ext_int
    {9'h111, 24'h020000},  // R3 ext_nmi
    {9'h112, 24'h040000},  // R3 ceng 0
    {9'h113, 24'h080000},  // R3 ceng 1
    {9'h180, 24'h100000},  // R4 nmi 0
    {9'h183, 24'h800000},  // R4 nmi 3
    {9'h003, 24'h000000},  // R5 valid clear
    {9'h114, 24'h000000},  // R5 request index 20
    {9'h11F, 24'h000000},  // R5 request index 31
    {9'h184, 24'h000000},  // R5 nmi index 4
    {9'h189, 24'h000000}   // R5 nmi index 9
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    wr_en = '0;
  logic [3:0]    wr_addr = '0;
  logic [2*DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [15:0]   core_virq;
  logic          ext_int;
  logic          ext_nmi;
  logic [1:0]    ceng_irq;
  logic [3:0]    core_vnmi;

  int  n_vec  = 0;
  int  n_miss = 0;
  bit  done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  soft_irq_gen u0 (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .core_virq (core_virq),
    .ext_int   (ext_int),
    .ext_nmi   (ext_nmi),
    .ceng_irq  (ceng_irq),
    .core_vnmi (core_vnmi)
  );

  function automatic logic [31:0] obs();
    return {8'h0, core_vnmi, ceng_irq, ext_nmi, ext_int, core_virq};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; one write cycle on the selected ports.
  task automatic wr_cycle(input logic [1:0] en, input logic [1:0] a0, input logic [31:0] d0,
                          input logic [1:0] a1, input logic [31:0] d1);
    wr_en   = en;
    wr_addr = {a1, a0};
    wr_data = {d1, d0};
    @(posedge clk);
    @(negedge clk);
    wr_en   = '0;
    wr_addr = '0;
    wr_data = '0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_en   = 1'b1;
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    v     = rd_data;
    rd_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk);
    idle();
    idle();
    // R1: reset state while reset is held
    check("R1 outputs in reset", obs(), 32'h0);
    rst = 1'b0;
    idle();
    rd(2'd1, v); check("R1 request status after reset", v, 32'h0);
    rd(2'd2, v); check("R1 nmi status after reset", v, 32'h0);

    // Vector table on port 0: pulse in the clock after the edge, gone one clock later.
    for (int k = 0; k < NVEC; k++) begin
      wr_cycle(2'b01, 2'd0, {23'h0, VEC[k][32:24]}, 2'd0, 32'h0);
      check($sformatf("R2/R3/R4/R5 pulse vec %0d", k), obs(), {8'h0, VEC[k][23:0]});
      idle();
      check($sformatf("R2/R3/R4/R5 single cycle vec %0d", k), obs(), 32'h0);
    end

    // R6, R5: accumulated status; ignored writes set nothing
    rd(2'd1, v); check("R6 R5 request status", v, 32'h000F8081);
    rd(2'd2, v); check("R6 R5 nmi status", v, 32'h00000009);
    rd(2'd0, v); check("R6 address 0 reads 0", v, 32'h0);
    rd(2'd3, v); check("R6 address 3 reads 0", v, 32'h0);
    // R11: read data is zero after an edge without rd_en
    idle();
    check("R11 rd_data idle", rd_data, 32'h0);

    // R8: write-one-to-clear, zero bits untouched
    wr_cycle(2'b01, 2'd1, 32'h00000080, 2'd0, 32'h0);
    check("R8 clear gives no pulse", obs(), 32'h0);
    rd(2'd1, v); check("R8 request clear bit 7", v, 32'h000F8001);
    wr_cycle(2'b01, 2'd2, 32'h00000001, 2'd0, 32'h0);
    rd(2'd2, v); check("R8 nmi clear bit 0", v, 32'h00000008);

    // R7: a set status bit does not block a new generation
    wr_cycle(2'b01, 2'd0, 32'h00000110, 2'd0, 32'h0);
    check("R7 repeat pulse ext_int", obs(), 32'h00010000);
    rd(2'd1, v); check("R7 status unchanged", v, 32'h000F8001);

    // R9: port 0 clears bits 0 and 15 while port 1 generates request 0
    wr_cycle(2'b11, 2'd1, 32'h00008001, 2'd0, 32'h00000100);
    check("R9 pulse during clear", obs(), 32'h00000001);
    rd(2'd1, v); check("R9 generate wins over clear", v, 32'h000F0001);

    // R10: both ports generate in the same edge
    wr_cycle(2'b11, 2'd0, 32'h00000102, 2'd0, 32'h00000181);
    check("R10 both pulses", obs(), 32'h00200004);
    idle();
    check("R10 pulses end", obs(), 32'h0);
    rd(2'd1, v); check("R10 request status", v, 32'h000F0005);
    rd(2'd2, v); check("R10 nmi status", v, 32'h0000000A);

    // R1: reset in mid-run clears status
    rst = 1'b1;
    idle();
    idle();
    rst = 1'b0;
    rd(2'd1, v); check("R1 request status after late reset", v, 32'h0);
    rd(2'd2, v); check("R1 nmi status after late reset", v, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

endmodule